// File: doc/BRIEF.md
# Microstep Stepper Motor Indexer

This block sequences the winding-current setpoints of a two-winding bipolar stepping motor. A slow step clock comes in from outside. The block synchronises it into the system clock domain, and each rising edge moves a 5-bit position index by one step. A direction input chooses whether the index moves up or down. A two-bit mode input picks one of four step resolutions. The index selects points on a quantised sine/cosine curve with a full scale of 100. The A winding follows the cosine and the B winding follows the sine. Both setpoints come out as signed 8-bit percentages.

An active-low reset holds the index at a home position, and that home position depends on the mode. An active-low enable blanks only the outputs; the index goes on counting steps while the outputs are blanked. An active-low flag marks the home position. A resolution change waits for the next step edge. At that edge the index first drops to the nearest valid position of the new resolution, then moves.

Top module: `stepper_indexer`

## Requirements
- R1: For modes 01, 10 and 11, at index p (0..31) the outputs are A = round(100·cos(2πp/32)) and B = round(100·sin(2πp/32)). The first quarter of the curve holds the magnitudes 0, 20, 38, 56, 71, 83, 92, 98, 100. No output ever exceeds ±100.
- R2: The mode decodes as follows. 00 = full step, 4 steps per cycle, stride 8. 01 = half step, 8 steps, stride 4. 10 = quarter step, 16 steps, stride 2. 11 = eighth step, 32 steps, stride 1.
- R3: In mode 00 the index sits only at positions 4, 12, 20 and 28. At those positions each output is +100 or −100, with the sign of the cosine (A) or sine (B).
- R4: With dir_ccw = 0 a step adds the stride to the index, modulo 32 (clockwise). With dir_ccw = 1 a step subtracts it.
- R5: While rst_n is low at a clock edge, the index is held at home: 28 in mode 00 (A = +100, B = −100), or 0 in the other modes (A = +100, B = 0). The mode is re-read on every clock edge while in reset.
- R6: at_home_n is 0 exactly when the index equals the home position of the latched mode. Otherwise it is 1.
- R7: The first step edge after reset release moves to the position one stride away from home.
- R8: With enable = 0, both drive-enable outputs are 0 and both setpoints read 0. The index keeps stepping. When enable returns to 1, the outputs show the current index.
- R9: A mode change leaves the outputs unchanged until the next step edge. At that edge the index is first rounded down to the new grid, then stepped.
  - Mode 00 grid: positions ≡ 4 mod 8, rounded as ((p−4) & ~7) + 4.
  - Other modes: rounded as p & ~(stride−1).
- R10: In half-step mode the diagonal positions give ±71 on both windings.
- R11: Each rising edge of step_clk produces exactly one step, however long step_clk stays high. With no rising edge the index holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, holds home position |
| step_clk | input | 1 | Asynchronous step clock, rising edge steps |
| dir_ccw | input | 1 | 0 = clockwise (index up), 1 = counter-clockwise |
| mode | input | 2 | Step resolution select |
| enable | input | 1 | Active-low output blanking |
| phase_a | output | 8 | Signed A-winding setpoint, percent |
| phase_b | output | 8 | Signed B-winding setpoint, percent |
| a_drive_en | output | 1 | A output driven (0 = high impedance) |
| b_drive_en | output | 1 | B output driven (0 = high impedance) |
| at_home_n | output | 1 | Low at home position, else released |

## Verification
The bench targets several corner cases.
- Mode-dependent home: a design with one fixed home would show B = 0 instead of −100 in full-step reset.
- First step after reset: a design with an off-by-one would land two strides away, or stay put.
- Rounding on a resolution change: a design that skipped rounding, or rounded to the wrong grid, would land at an odd index in full step, with non-±100 outputs.
- Counting while blanked: a design that froze the index under blanking would resume at the old position.
- Long step pulses: each high time lasts about 200 system clocks, so a level-sensitive design would step many times per pulse.

// File: rtl/stepper_pkg.sv
package stepper_pkg;

  localparam int IDX_W      = 5;
  localparam int IDX_N      = 1 << IDX_W;
  localparam int MAX_STRIDE = IDX_N / 4;
  localparam int AMP_W      = 8;
  localparam int FULL       = 100;

  typedef enum logic [1:0] {
    MODE_FULL    = 2'd0,
    MODE_HALF    = 2'd1,
    MODE_QUARTER = 2'd2,
    MODE_EIGHTH  = 2'd3
  } step_mode_e;

  // Index distance of one step in a given resolution.
  function automatic logic [IDX_W-1:0] stride_of(step_mode_e m);
    return IDX_W'(MAX_STRIDE >> int'(m));
  endfunction

  // Full step lives on the diagonals, half a coarse stride off zero.
  function automatic logic [IDX_W-1:0] grid_ofs(step_mode_e m);
    return (m == MODE_FULL) ? IDX_W'(MAX_STRIDE / 2) : '0;
  endfunction

  function automatic logic [IDX_W-1:0] home_idx(step_mode_e m);
    return (m == MODE_FULL) ? IDX_W'(IDX_N - MAX_STRIDE / 2) : '0;
  endfunction

  // Round an index down onto the grid of a resolution.
  function automatic logic [IDX_W-1:0] snap_idx(logic [IDX_W-1:0] p, step_mode_e m);
    logic [IDX_W-1:0] rel;
    rel = p - grid_ofs(m);
    rel = rel & ~(stride_of(m) - IDX_W'(1));
    return rel + grid_ofs(m);
  endfunction

  // First quarter of a sine, 8 intervals, full scale 100.
  function automatic int quarter_mag(int k);
    case (k)
      0:       return 0;
      1:       return 20;
      2:       return 38;
      3:       return 56;
      4:       return 71;
      5:       return 83;
      6:       return 92;
      7:       return 98;
      default: return FULL;
    endcase
  endfunction

  function automatic logic signed [AMP_W-1:0] sine_at(logic [IDX_W-1:0] p);
    int k;
    int m;
    k = int'(p[IDX_W-3:0]);
    case (p[IDX_W-1:IDX_W-2])
      2'd0:    m =  quarter_mag(k);
      2'd1:    m =  quarter_mag(MAX_STRIDE - k);
      2'd2:    m = -quarter_mag(k);
      default: m = -quarter_mag(MAX_STRIDE - k);
    endcase
    return AMP_W'(m);
  endfunction

endpackage

// File: rtl/step_edge_sync.sv
module step_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_clk,
  output logic fire
);
  logic prev_q;
  logic synced;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= step_clk;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= g_stage[g-1].q;
      end
    end
  end

  assign synced = g_stage[STAGES-1].q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= synced;
  end

  assign fire = synced & ~prev_q;

endmodule

// File: rtl/step_index_ctrl.sv
module step_index_ctrl
  import stepper_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             dir_ccw,
  input  step_mode_e       mode_in,
  output logic [IDX_W-1:0] idx,
  output step_mode_e       mode_q
);
  logic [IDX_W-1:0] snapped;
  logic [IDX_W-1:0] stride;
  logic [IDX_W-1:0] next_idx;

  always_comb begin
    snapped  = snap_idx(idx, mode_in);
    stride   = stride_of(mode_in);
    next_idx = dir_ccw ? (snapped - stride) : (snapped + stride);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= mode_in;
      idx    <= home_idx(mode_in);
    end else if (fire) begin
      mode_q <= mode_in;
      idx    <= next_idx;
    end
  end

  // R11: no edge, no movement
  a_r11_hold_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(idx));

  // R11: every edge moves the index
  a_r11_move_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> idx != $past(idx));

  // R9: the index always lies on the grid of the latched mode
  a_r9_on_grid: assert property (@(posedge clk) disable iff (!rst_n)
    ((idx - grid_ofs(mode_q)) & (stride_of(mode_q) - IDX_W'(1))) == '0);

endmodule

// File: rtl/phase_amp_lut.sv
module phase_amp_lut
  import stepper_pkg::*;
#(
  parameter int LEAD = 0
) (
  input  logic [IDX_W-1:0]        idx,
  input  step_mode_e              mode_q,
  output logic signed [AMP_W-1:0] amp
);
  logic [IDX_W-1:0]        pos;
  logic signed [AMP_W-1:0] raw;

  always_comb begin
    pos = idx + IDX_W'(LEAD);
    raw = sine_at(pos);
    if (mode_q == MODE_FULL) amp = (raw < 0) ? -AMP_W'(FULL) : AMP_W'(FULL);
    else                     amp = raw;
  end

endmodule

// File: rtl/stepper_indexer.sv
module stepper_indexer
  import stepper_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step_clk,
  input  logic                    dir_ccw,
  input  logic [1:0]              mode,
  input  logic                    enable,
  output logic signed [AMP_W-1:0] phase_a,
  output logic signed [AMP_W-1:0] phase_b,
  output logic                    a_drive_en,
  output logic                    b_drive_en,
  output logic                    at_home_n
);
  localparam int N_PHASE = 2;

  logic                    step_fire;
  logic [IDX_W-1:0]        idx;
  step_mode_e              mode_q;
  logic signed [AMP_W-1:0] amp [N_PHASE];

  step_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_clk (step_clk),
    .fire     (step_fire)
  );

  step_index_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (step_fire),
    .dir_ccw (dir_ccw),
    .mode_in (step_mode_e'(mode)),
    .idx     (idx),
    .mode_q  (mode_q)
  );

  // Phase 0 (A) leads by a quarter cycle: cosine. Phase 1 (B): sine.
  for (genvar g = 0; g < N_PHASE; g++) begin : g_phase
    phase_amp_lut #(.LEAD(g == 0 ? MAX_STRIDE : 0)) u_lut (
      .idx    (idx),
      .mode_q (mode_q),
      .amp    (amp[g])
    );
  end

  assign phase_a    = enable ? amp[0] : '0;
  assign phase_b    = enable ? amp[1] : '0;
  assign a_drive_en = enable;
  assign b_drive_en = enable;
  assign at_home_n  = (idx != home_idx(mode_q));

  // R1: setpoints stay within full scale
  a_r1_amp_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_a <= FULL) && (phase_a >= -FULL) && (phase_b <= FULL) && (phase_b >= -FULL));

  // R6: the home flag coincides with full positive A current
  a_r6_home_amp: assert property (@(posedge clk) disable iff (!rst_n)
    (!at_home_n && enable) |-> (phase_a == AMP_W'(FULL)));

endmodule

// File: tb/stepper_indexer_tb.sv
module stepper_indexer_tb;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              step_clk = 1'b0;
  logic              dir_ccw = 1'b0;
  logic [1:0]        mode = 2'd0;
  logic              enable = 1'b1;
  logic signed [7:0] phase_a, phase_b;
  logic              a_drive_en, b_drive_en, at_home_n;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // Bench model
  int pos_m = 0;
  int modeq_m = 0;

  always #4 clk = ~clk;

  stepper_indexer u_dut (
    .clk(clk), .rst_n(rst_n), .step_clk(step_clk), .dir_ccw(dir_ccw),
    .mode(mode), .enable(enable), .phase_a(phase_a), .phase_b(phase_b),
    .a_drive_en(a_drive_en), .b_drive_en(b_drive_en), .at_home_n(at_home_n)
  );

  function automatic int rnd100(real x);
    real y = 100.0 * x;
    if (y >= 0.0) return $rtoi(y + 0.5);
    return -$rtoi(-y + 0.5);
  endfunction

  function automatic int exp_amp(int p, int m, bit is_a);
    real ang = 2.0 * 3.14159265358979 * p / 32.0;
    int v = is_a ? rnd100($cos(ang)) : rnd100($sin(ang));
    if (m == 0) return (v < 0) ? -100 : 100;
    return v;
  endfunction

  function automatic int home_of(int m);
    return (m == 0) ? 28 : 0;
  endfunction

  function automatic int snap_of(int p, int m);
    int s = 8 >> m;
    int o = (m == 0) ? 4 : 0;
    return ((((p - o + 32) % 32) / s) * s + o) % 32;
  endfunction

  task automatic chk(string req, string what, int act, int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic check_all(string req);
    if (enable) begin
      chk(req, "phase_a", int'(phase_a), exp_amp(pos_m, modeq_m, 1'b1));
      chk(req, "phase_b", int'(phase_b), exp_amp(pos_m, modeq_m, 1'b0));
      chk(req, "drive_en", int'({a_drive_en, b_drive_en}), 3);
    end else begin
      chk(req, "blank phase_a", int'(phase_a), 0);
      chk(req, "blank phase_b", int'(phase_b), 0);
      chk(req, "blank drive_en", int'({a_drive_en, b_drive_en}), 0);
    end
    chk(req, "at_home_n", int'(at_home_n), (pos_m == home_of(modeq_m)) ? 0 : 1);
  endtask

  // One step pulse; 8400 cycles of 8 ns keeps the rate under 15 kHz
  // and the high time well over 100 ns.
  task automatic do_step(bit d);
    int s;
    dir_ccw = d;
    repeat (20) @(negedge clk);
    step_clk = 1'b1;
    repeat (200) @(negedge clk);
    step_clk = 1'b0;
    repeat (8180) @(negedge clk);
    modeq_m = int'(mode);
    s = 8 >> modeq_m;
    pos_m = snap_of(pos_m, modeq_m);
    pos_m = d ? (pos_m - s + 32) % 32 : (pos_m + s) % 32;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hang, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED);
    // R5: home per mode while in reset
    repeat (10) @(negedge clk);
    modeq_m = 0; pos_m = home_of(0);
    check_all("R5");
    for (int m = 1; m < 4; m++) begin
      mode = 2'(m);
      repeat (5) @(negedge clk);
      modeq_m = m; pos_m = home_of(m);
      check_all("R5");
    end
    // Release in half step, R6 home flag
    mode = 2'd1;
    repeat (5) @(negedge clk);
    modeq_m = 1; pos_m = 0;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_all("R6");
    // R7 first step after reset, R10 diagonal
    do_step(1'b0);
    chk("R7", "index after first step", pos_m, 4);
    chk("R10", "diag a", int'(phase_a), 71);
    chk("R10", "diag b", int'(phase_b), 71);
    do_step(1'b0); check_all("R4");
    do_step(1'b1); check_all("R4");
    do_step(1'b1); check_all("R6");
    // R8 blanking while stepping
    enable = 1'b0;
    do_step(1'b0); check_all("R8");
    enable = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R8");
    // R9 mode change only at the edge, R2 eighth step
    mode = 2'd3;
    repeat (20) @(negedge clk);
    check_all("R9");
    do_step(1'b0); check_all("R2");
    chk("R2", "eighth-step index", pos_m, 5);
    // R9 rounding onto full-step grid, R3
    mode = 2'd0;
    repeat (20) @(negedge clk);
    check_all("R9");
    do_step(1'b0); check_all("R3");
    chk("R3", "full-step a", int'(phase_a), -100);
    chk("R3", "full-step b", int'(phase_b), 100);
    // R2 quarter step, R9 rounding into half step
    mode = 2'd2;
    do_step(1'b1); check_all("R2");
    mode = 2'd1;
    do_step(1'b1); check_all("R9");
    // R1 / R11 random mix
    for (int i = 0; i < 9; i++) begin
      mode = 2'($urandom % 4);
      enable = ($urandom % 4) != 0;
      do_step(1'($urandom % 2));
      check_all("R1");
    end
    enable = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R11");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule